// File: doc/BRIEF.md
# PLL power sequencer

This block is a small state machine that owns the 28-bit control word of one PLL and carries out the PLL's safe enable and disable procedures in hardware. On a start request it first moves the system clock onto the reference input, if this instance serves the primary PLL. It then programs the multiplier and divider factors with the PLL powered and bypassed, and applies a reset pulse of bounded width. While it waits for every assigned lock bit, it pulses a slip-clear strobe. Once lock is seen it leaves bypass, sets the enable bit, and hands the system clock back to the PLL. On a stop request it bypasses the PLL before it removes power and enable, so clocks derived from it keep running.

The lock status word comes from outside the block. The lock field has a parameterised width and offset, and the slip-clear bit sits two positions above that field. The block writes the status word back with that bit forced to 1 during each strobe cycle. If lock does not arrive within a programmable number of cycles, the sequencer gives up. It raises an error flag and returns to idle with the PLL still in bypass. From the control word and the reference rate, the block also derives the output rate the PLL currently delivers.

States: IDLE (waits for a request), REF (selector to reference), PROG (factors, power and bypass written), RLO (reset driven low), RHI (reset held high), RREL (reset released), LOCK (lock wait with slip strobes), ENA (bypass cleared, enable set), RET (selector back to PLL), BYP (bypass set), OFF (power and enable cleared). Transitions: IDLE to REF on an accepted start. IDLE to BYP on a stop. Then REF to PROG to RLO to RHI, and RHI to RREL once reset has been high for the hold time. RREL goes to LOCK. LOCK goes to ENA on lock, or back to IDLE on timeout. ENA goes to RET, and RET to IDLE. BYP goes to OFF, and OFF to IDLE.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset the control word is all zero, the system clock selector `sysclk_pll` is 0 (reference), and `busy`, `pll_on`, `lock_err` and `lock_we` are 0.
- R2: An accepted start moves `sysclk_pll` to 0 in the first state. In the next state the block writes R to bits 3:0, F to bits 9:4, OD to bits 13:10, bandwidth to bits 19:14 and source select to bits 27:26, and sets power (bit 21) and bypass (bit 23) in the same write.
- R3: In a start sequence the reset bit (bit 20) is written low, then held high for RST_HOLD cycles (default 2), then written low again before the lock wait begins.
- R4: Lock counts as reached when every bit of the LOCK_W-wide field at LOCK_SHIFT in `lock_stat` is 1. In each cycle spent unlocked, `lock_we` toggles. While `lock_we` is high, `lock_wr_data` equals `lock_stat` with bit LOCK_SHIFT+2 forced to 1.
- R5: Once lock is seen, bypass is cleared and enable (bit 25) is set in one write. In the following cycle `sysclk_pll` returns to 1 for the primary PLL.
- R6: A stop request first sets bypass. One cycle later it clears power and enable.
- R7: The PLL counts as on when bit 20 is 0 and bits 21 and 25 are 1. While it is on, a start request is ignored: `busy` stays 0 and the control word does not change.
- R8: `busy` is high from the cycle after an accepted request until the sequence's final write. Start and stop requests that arrive while `busy` is high have no effect.
- R9: If lock is not reached after the wait counter hits `timeout_lim` (timeout_lim+1 lock-wait cycles), `lock_err` rises and the block returns to idle with bypass set and enable clear. `lock_err` clears on the next accepted start.
- R10: `rate_out` equals `in_rate` when bypass is set. It is 0 when power is clear. Otherwise it equals in_rate·(F+1)/((R+1)·(OD+1)), truncated.
- R11: When start and stop arrive in the same idle cycle and the start is accepted, the enable sequence runs.
- R12: When lock first appears in the cycle in which the timeout would expire, lock wins: no error, and the enable sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request to run the enable sequence |
| stop_req | input | 1 | Request to run the disable sequence |
| cfg_r | input | 4 | Reference divider value R |
| cfg_f | input | 6 | Feedback multiplier value F |
| cfg_od | input | 4 | Output divider value OD |
| cfg_bw | input | 6 | Loop bandwidth adjust value |
| cfg_src | input | 2 | PLL input source select |
| timeout_lim | input | TMO_W | Lock-wait limit in cycles |
| in_rate | input | RATE_W | Reference rate, any unit |
| lock_stat | input | STAT_W | Lock status word |
| pll_ctrl | output | 28 | PLL control word |
| sysclk_pll | output | 1 | System clock source: 1 = PLL, 0 = reference |
| lock_wr_data | output | STAT_W | Status word write-back with slip-clear bit set |
| lock_we | output | 1 | Write strobe for `lock_wr_data` |
| busy | output | 1 | A sequence is running |
| pll_on | output | 1 | PLL is powered, enabled and out of reset |
| lock_err | output | 1 | Last enable attempt timed out |
| rate_out | output | RATE_W+6 | Computed output rate |

## Verification
Two things can fall in the same cycle in this block. One is the lock-wait timeout expiring just as the lock field completes. The other is a start and a stop arriving together at an idle sequencer. The bench provokes the first by watching its own model's wait count and raising the lock bits exactly in the cycle whose edge would declare the timeout. It then judges that no error appears and that the PLL ends up on. The second is provoked with a single-cycle start and stop pulse. It is judged by the power bit two edges later: the enable path leaves the PLL powered, while the disable path would have cleared power.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int R_W    = 4;
    localparam int F_W    = 6;
    localparam int OD_W   = 4;
    localparam int BW_W   = 6;
    localparam int SRC_W  = 2;
    localparam int CTRL_W = 28;

    // Control word, MSB first: src[27:26] en[25] test[24] bypass[23]
    // fbint[22] pwrd[21] rst[20] bw[19:14] od[13:10] f[9:4] r[3:0]
    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             en;
        logic             test;
        logic             bypass;
        logic             fbint;
        logic             pwrd;
        logic             rst;
        logic [BW_W-1:0]  bw;
        logic [OD_W-1:0]  od;
        logic [F_W-1:0]   f;
        logic [R_W-1:0]   r;
    } pll_word_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REF,
        S_PROG,
        S_RLO,
        S_RHI,
        S_RREL,
        S_LOCK,
        S_ENA,
        S_RET,
        S_BYP,
        S_OFF
    } seq_state_t;
endpackage

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int RST_HOLD = 2,
    parameter int TMO_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             pll_on,
    input  logic             locked,
    input  logic [TMO_W-1:0] timeout_lim,
    output seq_state_t       state_q,
    output logic             tmo_hit,
    output logic             start_acc
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HOLD_W = $clog2(RST_HOLD + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_HOLD - 1);

    seq_state_t        state_d;
    logic [HOLD_W-1:0] hold_cnt;
    logic [TMO_W-1:0]  wait_cnt;

    assign start_acc = (state_q == S_IDLE) && start_req && !pll_on;
    assign tmo_hit   = (state_q == S_LOCK) && !locked && (wait_cnt >= timeout_lim);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_acc)     state_d = S_REF;
                else if (stop_req) state_d = S_BYP;
            end
            S_REF:  state_d = S_PROG;
            S_PROG: state_d = S_RLO;
            S_RLO:  state_d = S_RHI;
            S_RHI:  if (hold_cnt == HOLD_LAST) state_d = S_RREL;
            S_RREL: state_d = S_LOCK;
            S_LOCK: begin
                if (locked)       state_d = S_ENA;
                else if (tmo_hit) state_d = S_IDLE;
            end
            S_ENA:  state_d = S_RET;
            S_RET:  state_d = S_IDLE;
            S_BYP:  state_d = S_OFF;
            S_OFF:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            wait_cnt <= '0;
        end else begin
            if (state_q == S_RLO)      hold_cnt <= '0;
            else if (state_q == S_RHI) hold_cnt <= hold_cnt + HOLD_W'(1);
            if (state_q == S_RREL)     wait_cnt <= '0;
            else if (state_q == S_LOCK && !locked && !tmo_hit)
                wait_cnt <= wait_cnt + TMO_W'(1);
        end
    end

    // R8: no sequence restarts from a busy state
    p_no_restart_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> !(state_q inside {S_REF, S_BYP}));

    // R9: a timeout always lands in idle
    p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> (state_q == S_IDLE));
endmodule

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
    import pll_seq_pkg::*;
#(
    parameter bit PRIMARY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state_q,
    input  logic             locked,
    input  logic             tmo_hit,
    input  logic             start_acc,
    input  logic [R_W-1:0]   cfg_r,
    input  logic [F_W-1:0]   cfg_f,
    input  logic [OD_W-1:0]  cfg_od,
    input  logic [BW_W-1:0]  cfg_bw,
    input  logic [SRC_W-1:0] cfg_src,
    output pll_word_t        ctrl_q,
    output logic             sysclk_pll,
    output logic             slip_q,
    output logic             err_q
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            sysclk_pll <= 1'b0;
            slip_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            slip_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_acc) err_q <= 1'b0;
                S_REF:  if (PRIMARY) sysclk_pll <= 1'b0;
                S_PROG: begin
                    ctrl_q.r      <= cfg_r;
                    ctrl_q.f      <= cfg_f;
                    ctrl_q.od     <= cfg_od;
                    ctrl_q.bw     <= cfg_bw;
                    ctrl_q.src    <= cfg_src;
                    ctrl_q.pwrd   <= 1'b1;
                    ctrl_q.bypass <= 1'b1;
                end
                S_RLO:  ctrl_q.rst <= 1'b0;
                S_RHI:  ctrl_q.rst <= 1'b1;
                S_RREL: ctrl_q.rst <= 1'b0;
                S_LOCK: begin
                    if (!locked && !tmo_hit) slip_q <= ~slip_q;
                    if (tmo_hit)             err_q  <= 1'b1;
                end
                S_ENA: begin
                    ctrl_q.bypass <= 1'b0;
                    ctrl_q.en     <= 1'b1;
                end
                S_RET:  if (PRIMARY) sysclk_pll <= 1'b1;
                S_BYP:  ctrl_q.bypass <= 1'b1;
                S_OFF: begin
                    ctrl_q.pwrd <= 1'b0;
                    ctrl_q.en   <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R2: the system clock stays on the reference while the PLL is reworked
    p_sel_ref_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {S_PROG, S_RLO, S_RHI, S_RREL, S_LOCK, S_ENA}) |-> !sysclk_pll);

    // R3: reset held high at least two cycles before it falls
    p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.rst) |-> $past(ctrl_q.rst, 2));

    // R4: the slip strobe only appears during the lock wait
    p_slip_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slip_q |-> (state_q == S_LOCK));

    // R5: enable rises only on a powered, released, unbypassed PLL
    p_en_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.en) |-> (!ctrl_q.bypass && ctrl_q.pwrd && !ctrl_q.rst));

    // R6: power is removed only after bypass was already set
    p_bypass_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.pwrd) |-> (ctrl_q.bypass && $past(ctrl_q.bypass)));

    // R9: an error leaves the PLL bypassed and disabled
    p_err_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (ctrl_q.bypass && !ctrl_q.en));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_seq_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  pll_word_t           ctrl,
    input  logic [RATE_W-1:0]   in_rate,
    output logic [RATE_W+F_W-1:0] rate_out
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PROD_W = RATE_W + F_W;
    localparam int DEN_W  = R_W + OD_W + 2;

    logic [F_W:0]        f_plus;
    logic [R_W:0]        r_plus;
    logic [OD_W:0]       od_plus;
    logic [DEN_W-1:0]    den;
    logic [PROD_W-1:0]   num;
    logic [PROD_W-1:0]   quot;

    always_comb begin
        f_plus  = {1'b0, ctrl.f}  + (F_W+1)'(1);
        r_plus  = {1'b0, ctrl.r}  + (R_W+1)'(1);
        od_plus = {1'b0, ctrl.od} + (OD_W+1)'(1);
        den     = DEN_W'(r_plus) * DEN_W'(od_plus);
        num     = PROD_W'(in_rate) * PROD_W'(f_plus);
        quot    = num / PROD_W'(den);
        if (ctrl.bypass)    rate_out = PROD_W'(in_rate);
        else if (!ctrl.pwrd) rate_out = '0;
        else                rate_out = quot;
    end
endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
    import pll_seq_pkg::*;
#(
    parameter bit PRIMARY    = 1'b1,
    parameter int LOCK_SHIFT = 0,
    parameter int LOCK_W     = 2,
    parameter int STAT_W     = 8,
    parameter int RST_HOLD   = 2,
    parameter int TMO_W      = 16,
    parameter int RATE_W     = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_req,
    input  logic                   stop_req,
    input  logic [R_W-1:0]         cfg_r,
    input  logic [F_W-1:0]         cfg_f,
    input  logic [OD_W-1:0]        cfg_od,
    input  logic [BW_W-1:0]        cfg_bw,
    input  logic [SRC_W-1:0]       cfg_src,
    input  logic [TMO_W-1:0]       timeout_lim,
    input  logic [RATE_W-1:0]      in_rate,
    input  logic [STAT_W-1:0]      lock_stat,
    output logic [CTRL_W-1:0]      pll_ctrl,
    output logic                   sysclk_pll,
    output logic [STAT_W-1:0]      lock_wr_data,
    output logic                   lock_we,
    output logic                   busy,
    output logic                   pll_on,
    output logic                   lock_err,
    output logic [RATE_W+F_W-1:0]  rate_out
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SLIP_POS = LOCK_SHIFT + 2;

    seq_state_t state_q;
    pll_word_t  ctrl_q;
    logic       locked;
    logic       tmo_hit;
    logic       start_acc;
    logic       slip_q;

    assign locked       = &lock_stat[LOCK_SHIFT +: LOCK_W];
    assign pll_on       = !ctrl_q.rst && ctrl_q.pwrd && ctrl_q.en;
    assign busy         = (state_q != S_IDLE);
    assign pll_ctrl     = ctrl_q;
    assign lock_we      = slip_q;
    assign lock_wr_data = lock_stat | (STAT_W'(slip_q) << SLIP_POS);

    pll_seq_fsm #(
        .RST_HOLD (RST_HOLD),
        .TMO_W    (TMO_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .pll_on      (pll_on),
        .locked      (locked),
        .timeout_lim (timeout_lim),
        .state_q     (state_q),
        .tmo_hit     (tmo_hit),
        .start_acc   (start_acc)
    );

    pll_seq_regs #(
        .PRIMARY (PRIMARY)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .locked     (locked),
        .tmo_hit    (tmo_hit),
        .start_acc  (start_acc),
        .cfg_r      (cfg_r),
        .cfg_f      (cfg_f),
        .cfg_od     (cfg_od),
        .cfg_bw     (cfg_bw),
        .cfg_src    (cfg_src),
        .ctrl_q     (ctrl_q),
        .sysclk_pll (sysclk_pll),
        .slip_q     (slip_q),
        .err_q      (lock_err)
    );

    pll_rate_calc #(
        .RATE_W (RATE_W)
    ) u_rate (
        .ctrl     (ctrl_q),
        .in_rate  (in_rate),
        .rate_out (rate_out)
    );

    // R7: a start on a running PLL never raises busy
    p_start_ignored_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pll_on && start_req && !stop_req) |=> !busy);
endmodule

// File: tb/pll_pwr_seq_test.sv
module pll_pwr_seq_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int P_IDLE = 0, P_REF = 1, P_PROG = 2, P_RLO = 3, P_RHI = 4,
                   P_RREL = 5, P_LOCK = 6, P_ENA = 7, P_RET = 8, P_BYP = 9, P_OFF = 10;
    localparam int HOLD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0, stop_req = 1'b0;
    logic [3:0]  cfg_r = 4'd0;
    logic [5:0]  cfg_f = 6'd59;
    logic [3:0]  cfg_od = 4'd1;
    logic [5:0]  cfg_bw = 6'd59;
    logic [1:0]  cfg_src = 2'd2;
    logic [15:0] timeout_lim = 16'd20;
    logic [31:0] in_rate = 32'd26000;
    logic [7:0]  lock_stat = 8'h00;
    logic [27:0] pll_ctrl;
    logic        sysclk_pll;
    logic [7:0]  lock_wr_data;
    logic        lock_we, busy, pll_on, lock_err;
    logic [37:0] rate_out;

    pll_pwr_seq uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .cfg_r(cfg_r), .cfg_f(cfg_f), .cfg_od(cfg_od), .cfg_bw(cfg_bw),
        .cfg_src(cfg_src), .timeout_lim(timeout_lim), .in_rate(in_rate),
        .lock_stat(lock_stat), .pll_ctrl(pll_ctrl), .sysclk_pll(sysclk_pll),
        .lock_wr_data(lock_wr_data), .lock_we(lock_we), .busy(busy),
        .pll_on(pll_on), .lock_err(lock_err), .rate_out(rate_out)
    );

    always #2.5 clk = ~clk;  // 200 MHz

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_ph = P_IDLE;
    logic [27:0] m_ctrl = '0;
    logic        m_sel = 1'b0, m_slip = 1'b0, m_err = 1'b0;
    int          m_hold = 0, m_wait = 0;

    always @(posedge clk) begin
        bit m_on, lk, nslip;
        if (!rst_n) begin
            m_ph = P_IDLE; m_ctrl = '0; m_sel = 0; m_slip = 0; m_err = 0;
            m_hold = 0; m_wait = 0;
        end else begin
            m_on  = !m_ctrl[20] && m_ctrl[21] && m_ctrl[25];
            lk    = (lock_stat[1:0] == 2'b11);
            nslip = 1'b0;
            case (m_ph)
                P_IDLE: if (start_req && !m_on) begin m_err = 0; m_ph = P_REF; end
                        else if (stop_req) m_ph = P_BYP;
                P_REF:  begin m_sel = 0; m_ph = P_PROG; end
                P_PROG: begin
                    m_ctrl[19:0]  = {cfg_bw, cfg_od, cfg_f, cfg_r};
                    m_ctrl[27:26] = cfg_src;
                    m_ctrl[21] = 1; m_ctrl[23] = 1; m_ph = P_RLO;
                end
                P_RLO:  begin m_ctrl[20] = 0; m_hold = 0; m_ph = P_RHI; end
                P_RHI:  begin m_ctrl[20] = 1; m_hold++; if (m_hold == HOLD) m_ph = P_RREL; end
                P_RREL: begin m_ctrl[20] = 0; m_wait = 0; m_ph = P_LOCK; end
                P_LOCK: begin
                    if (lk) m_ph = P_ENA;
                    else if (m_wait >= int'(timeout_lim)) begin m_err = 1; m_ph = P_IDLE; end
                    else begin nslip = !m_slip; m_wait++; end
                end
                P_ENA:  begin m_ctrl[23] = 0; m_ctrl[25] = 1; m_ph = P_RET; end
                P_RET:  begin m_sel = 1; m_ph = P_IDLE; end
                P_BYP:  begin m_ctrl[23] = 1; m_ph = P_OFF; end
                P_OFF:  begin m_ctrl[21] = 0; m_ctrl[25] = 0; m_ph = P_IDLE; end
                default: m_ph = P_IDLE;
            endcase
            m_slip = nslip;
        end
    end

    function automatic longint m_rate();
        longint f1, r1, o1;
        f1 = longint'(m_ctrl[9:4]) + 1;
        r1 = longint'(m_ctrl[3:0]) + 1;
        o1 = longint'(m_ctrl[13:10]) + 1;
        if (m_ctrl[23]) return longint'(in_rate);
        if (!m_ctrl[21]) return 0;
        return (longint'(in_rate) * f1) / (r1 * o1);
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] exp_wr;
            exp_wr = lock_stat | (m_slip ? 8'h04 : 8'h00);
            chk("R2 factors/src/power", {pll_ctrl[27:26], pll_ctrl[21], pll_ctrl[19:0]},
                {m_ctrl[27:26], m_ctrl[21], m_ctrl[19:0]});
            chk("R3 reset bit", pll_ctrl[20], m_ctrl[20]);
            chk("R5 R6 bypass/enable", {pll_ctrl[25], pll_ctrl[23]}, {m_ctrl[25], m_ctrl[23]});
            chk("R5 selector", sysclk_pll, m_sel);
            chk("R4 slip strobe", lock_we, m_slip);
            if (m_slip) chk("R4 slip write data", lock_wr_data, exp_wr);
            chk("R8 busy", busy, m_ph != P_IDLE);
            chk("R7 pll_on", pll_on, !m_ctrl[20] && m_ctrl[21] && m_ctrl[25]);
            chk("R9 lock_err", lock_err, m_err);
            chk("R10 rate", rate_out, m_rate());
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R8: actual=busy-hang expected=finish");
            summary();
            $finish;
        end
    end

    task automatic pulse(input bit s, input bit p);
        start_req = s; stop_req = p;
        @(negedge clk);
        start_req = 0; stop_req = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", pll_ctrl, 0);
        chk("R1 selector", sysclk_pll, 0);
        chk("R1 busy", busy, 0);
        chk("R1 on", pll_on, 0);
        chk("R1 err", lock_err, 0);
        chk("R1 strobe", lock_we, 0);
        chk("R10 rate zero when unpowered", rate_out, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 R3 R4 R5 R8: full enable, requests injected while busy
        pulse(1, 0);
        chk("R2 selector to reference", sysclk_pll, 1'b0);
        repeat (3) @(negedge clk);
        pulse(1, 1);
        pulse(0, 1);
        chk("R8 busy holds through ignored requests", busy, 1);
        while (m_ph != P_LOCK) @(negedge clk);
        repeat (4) @(negedge clk);
        lock_stat = 8'hA3;
        wait_idle();
        chk("R5 on after lock", pll_on, 1);
        chk("R5 selector back to PLL", sysclk_pll, 1);
        chk("R10 rate 780000", rate_out, 780000);

        // R7 start ignored while on
        pulse(1, 0);
        chk("R7 busy stays low", busy, 0);
        chk("R7 ctrl unchanged", pll_ctrl, m_ctrl);

        // R6 stop ordering
        pulse(0, 1);
        @(negedge clk);
        chk("R6 bypass set, power kept", {pll_ctrl[23], pll_ctrl[21]}, 2'b11);
        @(negedge clk);
        chk("R6 power and enable cleared", {pll_ctrl[25], pll_ctrl[21]}, 2'b00);
        chk("R10 bypass rate", rate_out, 26000);
        wait_idle();

        // R9 timeout with partial lock
        cfg_r = 4'd1; cfg_f = 6'd9; cfg_od = 4'd0; cfg_src = 2'd1;
        timeout_lim = 16'd5; lock_stat = 8'h01;
        pulse(1, 0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R9 busy cycles until timeout", n, 12);
        chk("R9 err raised", lock_err, 1);
        chk("R9 bypass kept", pll_ctrl[23], 1);
        chk("R9 enable clear", pll_ctrl[25], 0);

        // R11 start and stop together
        lock_stat = 8'h03;
        pulse(1, 1);
        repeat (2) @(negedge clk);
        chk("R11 start wins, power set", pll_ctrl[21], 1);
        wait_idle();
        chk("R9 err cleared by new start", lock_err, 0);
        chk("R11 on", pll_on, 1);
        chk("R10 rate 130000", rate_out, 130000);

        // R12 lock arrives on the timeout cycle
        pulse(0, 1);
        wait_idle();
        lock_stat = 8'h00; timeout_lim = 16'd4;
        pulse(1, 0);
        while (!(m_ph == P_LOCK && m_wait == 4)) @(negedge clk);
        lock_stat = 8'h03;
        wait_idle();
        chk("R12 no error when lock meets timeout", lock_err, 0);
        chk("R12 on", pll_on, 1);

        summary();
        $finish;
    end
endmodule